// File: doc/BRIEF.md
# Split-Transaction Queue-Head Controller

This block steers one asynchronous queue head through a hub's transaction translator. It serves full-speed and low-speed endpoints that sit behind a high-speed hub. The block has two named states. START_SPLIT (`state` = 0) issues the start-split transaction, and COMPLETE_SPLIT (`state` = 1) issues the complete-split transaction. Each time the schedule visits the queue head, the block asks the bus engine to run the split transaction that matches its current state. It then takes in the classified handshake from the bus engine, together with the PID code and a flag that says whether the microframe still has time for another transaction.

From each result the block decides four things: the next state, what happens to the 2-bit error counter, whether the endpoint halts, and whether the sticky transaction-error bit gets set. It sends back exactly one action for each result. The action is either an advance to the next queue head or an immediate retry of the complete-split. The transitions are named as follows:
- SS_ACK: START_SPLIT to COMPLETE_SPLIT.
- SS_HOLD: START_SPLIT to START_SPLIT, on NAK, NYET or a transaction error.
- CS_NYET: COMPLETE_SPLIT to COMPLETE_SPLIT.
- CS_ERR: COMPLETE_SPLIT to COMPLETE_SPLIT, with a retry or an advance.
- CS_DONE: COMPLETE_SPLIT to START_SPLIT.
- HALT: from either state, on STALL or when the counter is exhausted.

A re-arm pulse returns the block to START_SPLIT and loads a programmed counter value. A programmed value of zero turns off error counting.

Top module: `split_qh_ctrl`

## Requirements
- R1: Reset puts the block in START_SPLIT (`state`=0) with the counter at 3, `halted`=0 and `xact_err`=0. A pulse on `arm` restores the same state but loads the counter from `init_cerr`. `arm` takes priority over a result in the same cycle.
- R2: A `visit` pulse on a non-halted queue head produces an `issue` pulse on the next cycle. `issue_csplit` equals `state` at the time of the visit.
- R3: In START_SPLIT, an ACK (`res_code`=5'b00001) moves the block to COMPLETE_SPLIT and advances. The counter reloads to 3 when `pid` is OUT (2'b00) or IN (2'b01). It stays unchanged when `pid` is SETUP (2'b10). A `pid` of 2'b11 behaves like IN/OUT.
- R4: In START_SPLIT, a NAK (5'b00010) keeps the state, advances, and leaves the counter unchanged.
- R5: In START_SPLIT, a NYET (5'b00100) or a transaction error decrements the counter, keeps the state and advances. A transaction error is code 5'b10000, or any code that is not exactly one-hot.
- R6: In COMPLETE_SPLIT, a NYET keeps the state and advances. The counter reloads to 3 for IN/OUT and stays unchanged for SETUP.
- R7: In COMPLETE_SPLIT, an ACK or a NAK returns the block to START_SPLIT and advances, with the counter unchanged.
- R8: In COMPLETE_SPLIT, a transaction error sets `xact_err`, decrements the counter and keeps COMPLETE_SPLIT, for any PID. If the block does not halt, it pulses `retry` when `time_ok`=1 and `advance` when `time_ok`=0.
- R9: A STALL (5'b01000) in either state sets `halted` and advances, with the state and counter unchanged.
- R10: A decrement that takes the counter from 1 to 0 sets `halted` and advances, never retries.
- R11: While the counter is 0, error results do not change it and never halt.
- R12: While `halted`=1, results and visits have no effect. There are no pulses and no state or counter change until `arm`.
- R13: Every accepted result produces exactly one of `advance` or `retry`, one cycle after `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Re-arm pulse |
| init_cerr | input | 2 | Counter value loaded by `arm` |
| visit | input | 1 | Schedule visits this queue head |
| res_valid | input | 1 | Result present this cycle |
| res_code | input | 5 | One-hot result: bit0 ACK, bit1 NAK, bit2 NYET, bit3 STALL, bit4 transaction error |
| pid | input | 2 | 00 OUT, 01 IN, 10 SETUP |
| time_ok | input | 1 | Microframe has room for a retry |
| issue | output | 1 | Request the split transaction (pulse) |
| issue_csplit | output | 1 | 1 selects complete-split, 0 selects start-split |
| advance | output | 1 | Move on to the next queue head (pulse) |
| retry | output | 1 | Reissue the complete-split now (pulse) |
| halted | output | 1 | Endpoint halted |
| state | output | 1 | 0 START_SPLIT, 1 COMPLETE_SPLIT |
| cerr | output | 2 | Error counter |
| xact_err | output | 1 | Sticky complete-split transaction-error bit |

## Verification
The bench targets the PID dependence of the counter. A design that reloads on SETUP would let a failing control transfer retry forever. It also targets the retry path that depends on the time flag. A design that leaves COMPLETE_SPLIT when time runs out would resend a start-split the hub never expected. The bench drives the counter down to exactly one and then sends an error, which catches a halt that fires one error early or one error late. It also runs with a programmed count of zero, where a wrong design would wrap the counter to 3 or halt. Non-one-hot codes, results sent while halted, and `arm` colliding with a result are all mixed into a seeded random stream.

// File: rtl/split_qh_pkg.sv
package split_qh_pkg;

    typedef enum logic {
        SP_START    = 1'b0,
        SP_COMPLETE = 1'b1
    } sp_state_e;

    localparam int RESP_W = 5;

    localparam int RB_ACK   = 0;
    localparam int RB_NAK   = 1;
    localparam int RB_NYET  = 2;
    localparam int RB_STALL = 3;
    localparam int RB_XERR  = 4;

    localparam logic [1:0] PID_SETUP = 2'b10;

    typedef struct packed {
        logic ack;
        logic nak;
        logic nyet;
        logic stall;
        logic xerr;
    } resp_t;

endpackage

// File: rtl/split_resp_decode.sv
module split_resp_decode
    import split_qh_pkg::*;
#(
    parameter int CODE_W = RESP_W
) (
    input  logic [CODE_W-1:0] code,
    output resp_t             resp
);
    logic single_hot;

    always_comb begin
        single_hot = (code != '0) && ((code & (code - 1'b1)) == '0);
        resp.ack   = single_hot && code[RB_ACK];
        resp.nak   = single_hot && code[RB_NAK];
        resp.nyet  = single_hot && code[RB_NYET];
        resp.stall = single_hot && code[RB_STALL];
        // anything malformed is handled like a bus error
        resp.xerr  = !single_hot || code[RB_XERR];
    end
endmodule

// File: rtl/split_err_counter.sv
module split_err_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         at_one
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= FULL;
        end else if (load) begin
            cnt <= load_val;
        end else if (reload) begin
            cnt <= FULL;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign at_one = (cnt == ONE);
endmodule

// File: rtl/split_qh_ctrl.sv
module split_qh_ctrl
    import split_qh_pkg::*;
#(
    parameter int CERR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [CERR_W-1:0] init_cerr,
    input  logic              visit,
    input  logic              res_valid,
    input  logic [RESP_W-1:0] res_code,
    input  logic [1:0]        pid,
    input  logic              time_ok,
    output logic              issue,
    output logic              issue_csplit,
    output logic              advance,
    output logic              retry,
    output logic              halted,
    output logic              state,
    output logic [CERR_W-1:0] cerr,
    output logic              xact_err
);
    sp_state_e cur_q, nxt;
    resp_t     rsp;
    logic      accept, is_setup;
    logic      do_reload, do_dec, do_halt, do_seterr, do_adv, do_retry;
    logic      at_one;

    split_resp_decode #(.CODE_W(RESP_W)) i_dec (
        .code (res_code),
        .resp (rsp)
    );

    split_err_counter #(.W(CERR_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (init_cerr),
        .reload   (do_reload),
        .dec      (do_dec),
        .cnt      (cerr),
        .at_one   (at_one)
    );

    assign accept   = res_valid && !halted && !arm;
    assign is_setup = (pid == PID_SETUP);

    // next-state and action decode
    always_comb begin
        nxt       = cur_q;
        do_reload = 1'b0;
        do_dec    = 1'b0;
        do_halt   = 1'b0;
        do_seterr = 1'b0;
        do_adv    = 1'b0;
        do_retry  = 1'b0;
        if (accept) begin
            unique case (cur_q)
                SP_START: begin
                    do_adv = 1'b1;
                    if (rsp.stall) begin
                        do_halt = 1'b1;
                    end else if (rsp.ack) begin
                        nxt       = SP_COMPLETE;
                        do_reload = !is_setup;
                    end else if (rsp.nyet || rsp.xerr) begin
                        do_dec  = 1'b1;
                        do_halt = at_one;
                    end
                end
                SP_COMPLETE: begin
                    if (rsp.stall) begin
                        do_halt = 1'b1;
                        do_adv  = 1'b1;
                    end else if (rsp.nyet) begin
                        do_reload = !is_setup;
                        do_adv    = 1'b1;
                    end else if (rsp.xerr) begin
                        do_seterr = 1'b1;
                        do_dec    = 1'b1;
                        do_halt   = at_one;
                        do_retry  = !at_one && time_ok;
                        do_adv    = !do_retry;
                    end else begin
                        nxt    = SP_START;
                        do_adv = 1'b1;
                    end
                end
                default: nxt = SP_START;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= SP_START;
        end else if (arm) begin
            cur_q <= SP_START;
        end else begin
            cur_q <= nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            advance      <= 1'b0;
            retry        <= 1'b0;
            halted       <= 1'b0;
            xact_err     <= 1'b0;
            issue        <= 1'b0;
            issue_csplit <= 1'b0;
        end else if (arm) begin
            advance      <= 1'b0;
            retry        <= 1'b0;
            halted       <= 1'b0;
            xact_err     <= 1'b0;
            issue        <= 1'b0;
            issue_csplit <= 1'b0;
        end else begin
            advance      <= do_adv;
            retry        <= do_retry;
            halted       <= halted || do_halt;
            xact_err     <= xact_err || do_seterr;
            issue        <= visit && !halted;
            issue_csplit <= (cur_q == SP_COMPLETE);
        end
    end

    assign state = cur_q;
endmodule

// File: rtl/split_qh_checker.sv
module split_qh_checker #(
    parameter int CERR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              res_valid,
    input logic [4:0]        res_code,
    input logic              time_ok,
    input logic              issue,
    input logic              advance,
    input logic              retry,
    input logic              halted,
    input logic              state,
    input logic [CERR_W-1:0] cerr
);
    localparam logic [CERR_W-1:0] FULL = {CERR_W{1'b1}};

    p_one_action_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({advance, retry}) <= 1);

    p_action_after_result_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (advance || retry) |-> ($past(res_valid) && !$past(halted) && !$past(arm)));

    p_retry_needs_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> ($past(time_ok) && state));

    p_quiet_when_halted_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !issue);

    p_counter_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(arm) && cerr != $past(cerr)) |->
            (cerr == FULL || (cerr + CERR_W'(1)) == $past(cerr)));

    p_enter_complete_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(arm) && state && !$past(state)) |-> ($past(res_code) == 5'b00001));
endmodule

bind split_qh_ctrl split_qh_checker #(.CERR_W(CERR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .res_valid (res_valid),
    .res_code  (res_code),
    .time_ok   (time_ok),
    .issue     (issue),
    .advance   (advance),
    .retry     (retry),
    .halted    (halted),
    .state     (state),
    .cerr      (cerr)
);

// File: tb/test_split_qh_ctrl.sv
module test_split_qh_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic [1:0] init_cerr = 2'd0;
    logic       visit = 1'b0;
    logic       res_valid = 1'b0;
    logic [4:0] res_code = 5'd0;
    logic [1:0] pid = 2'd0;
    logic       time_ok = 1'b0;
    logic       issue, issue_csplit, advance, retry, halted, state, xact_err;
    logic [1:0] cerr;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [1:0] m_cerr;
    logic       m_st, m_halt, m_err;

    always #2 clk = ~clk;

    split_qh_ctrl i_split_qh_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .init_cerr(init_cerr), .visit(visit),
        .res_valid(res_valid), .res_code(res_code), .pid(pid), .time_ok(time_ok),
        .issue(issue), .issue_csplit(issue_csplit), .advance(advance), .retry(retry),
        .halted(halted), .state(state), .cerr(cerr), .xact_err(xact_err)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] snap();
        return {1'b0, advance, retry, state, cerr, halted, xact_err};
    endfunction

    function automatic logic [7:0] mexp(input logic ea, input logic er);
        return {1'b0, ea, er, m_st, m_cerr, m_halt, m_err};
    endfunction

    task automatic mdec(output bit zeroed);
        zeroed = 0;
        if (m_cerr != 2'd0) begin
            if (m_cerr == 2'd1) begin
                m_halt = 1'b1;
                zeroed = 1;
            end
            m_cerr = m_cerr - 2'd1;
        end
    endtask

    task automatic send(input logic [4:0] code, input logic [1:0] p, input logic tok);
        string tag;
        logic  ea = 1'b0, er = 1'b0;
        bit    oh = (code != 0) && ((code & (code - 5'd1)) == 0);
        bit    ack = oh && code[0], nak = oh && code[1], nyet = oh && code[2];
        bit    stall = oh && code[3], xe = !oh || code[4];
        bit    z;
        if (m_halt) begin
            tag = "R12";
        end else if (stall) begin
            m_halt = 1'b1; ea = 1'b1; tag = "R9";
        end else if (!m_st) begin
            ea = 1'b1;
            if (ack) begin
                m_st = 1'b1; tag = "R3";
                if (p != 2'b10) m_cerr = 2'd3;
            end else if (nak) begin
                tag = "R4";
            end else begin
                tag = (m_cerr == 0) ? "R11" : "R5";
                mdec(z);
                if (z) tag = "R10";
            end
        end else begin
            if (nyet) begin
                ea = 1'b1; tag = "R6";
                if (p != 2'b10) m_cerr = 2'd3;
            end else if (xe) begin
                m_err = 1'b1; tag = (m_cerr == 0) ? "R11" : "R8";
                mdec(z);
                if (z) begin
                    ea = 1'b1; tag = "R10";
                end else if (tok) er = 1'b1;
                else ea = 1'b1;
            end else begin
                m_st = 1'b0; ea = 1'b1; tag = "R7";
            end
        end
        @(negedge clk);
        res_valid = 1'b1; res_code = code; pid = p; time_ok = tok;
        @(negedge clk);
        res_valid = 1'b0;
        check(tag, snap(), mexp(ea, er));
    endtask

    task automatic do_visit();
        @(negedge clk);
        visit = 1'b1;
        @(negedge clk);
        visit = 1'b0;
        check(m_halt ? "R12" : "R2", {6'd0, issue, issue & issue_csplit},
              {6'd0, !m_halt, !m_halt & m_st});
    endtask

    task automatic do_arm(input logic [1:0] v);
        @(negedge clk);
        arm = 1'b1; init_cerr = v;
        @(negedge clk);
        arm = 1'b0;
        m_cerr = v; m_st = 1'b0; m_halt = 1'b0; m_err = 1'b0;
        check("R1", snap(), mexp(1'b0, 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cerr = 2'd3; m_st = 1'b0; m_halt = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", snap(), mexp(1'b0, 1'b0));

        // directed corner cases
        do_visit();                        // R2 start-split issue
        send(5'b00001, 2'b01, 1'b1);       // R3 ACK IN
        do_visit();                        // R2 complete-split issue
        send(5'b10000, 2'b00, 1'b1);       // R8 retry
        send(5'b10000, 2'b10, 1'b0);       // R8 no time -> advance
        send(5'b00100, 2'b10, 1'b0);       // R6 SETUP hold
        send(5'b00100, 2'b00, 1'b0);       // R6 reload
        send(5'b00010, 2'b00, 1'b0);       // R7 NAK back to start
        send(5'b00010, 2'b00, 1'b0);       // R4
        send(5'b00100, 2'b00, 1'b0);       // R5 NYET in start
        send(5'b00011, 2'b00, 1'b0);       // R5 malformed
        send(5'b00001, 2'b10, 1'b0);       // R3 SETUP hold
        send(5'b10000, 2'b10, 1'b1);       // R10 hits zero
        do_visit();                        // R12 no issue
        send(5'b00001, 2'b00, 1'b0);       // R12 ignored
        do_arm(2'd0);
        send(5'b10000, 2'b00, 1'b1);       // R11
        send(5'b00001, 2'b10, 1'b0);
        send(5'b10000, 2'b00, 1'b1);       // R11 in complete
        send(5'b01000, 2'b00, 1'b1);       // R9
        do_arm(2'd2);
        send(5'b00001, 2'b00, 1'b0);
        send(5'b01000, 2'b00, 1'b1);       // R9 in complete

        // seeded random stream
        for (int i = 0; i < 1500; i++) begin
            int r = $urandom_range(99);
            if (r < 4) begin
                do_arm(2'($urandom_range(3)));
            end else if (r < 20) begin
                do_visit();
            end else begin
                logic [4:0] c;
                if ($urandom_range(19) == 0) c = 5'($urandom_range(31));
                else c = 5'd1 << $urandom_range(4);
                send(c, 2'($urandom_range(2)), 1'($urandom_range(1)));
            end
        end
        finish_run();
    end
endmodule